// File: doc/BRIEF.md
# Strip Hit Deserializer and Address Encoder

This block receives the comparator hit bits of one 64-channel front-end readout chip over eight serial lanes running at the fast clock. Every sample period each lane delivers one byte, most significant bit first. A frame strobe marks the cycle that carries the eighth bit. On that strobe the block rebuilds the 64-bit hit pattern of the sample and tags it with the value of the global timestamp counter.

A pattern with no hits is discarded at once. A pattern with hits is held in a one-slice backlog and then drained by an address encoder. The encoder emits one word per hit strip over a valid/ready stream, lowest strip first. Each word carries the slice timestamp and a global 9-bit strip coordinate, and the last word of a slice is flagged. If a new non-empty pattern arrives while the backlog is still occupied, the new pattern is dropped and an overflow pulse is raised.

Top module: `strip_hit_decoder`

## Requirements
- R1: Lane k carries pattern bits 8k+7 down to 8k, most significant first. The bit present on lane k in the cycle where `frame_i` is high becomes pattern bit 8k. The bit received seven cycles earlier becomes bit 8k+7.
- R2: Every output word of a slice carries the value `ts_i` had in that slice's frame cycle.
- R3: A pattern with all 64 bits clear produces no output word and does not raise `overflow_o`.
- R4: A non-empty slice emits exactly one word per set bit, in ascending strip order. `out_last` is 1 on the final word of the slice and 0 on all others.
- R5: `out_addr` is {SIDE_ID (bit 8), CHIP_ID (bits 7:6), local strip index 0..63 (bits 5:0)}.
- R6: One word is accepted per clock while `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_ts` and `out_last` hold their values.
- R7: One non-empty slice can wait in the backlog while another drains, and it follows with no idle cycle between them. Suppose a non-empty pattern is framed while the backlog is occupied and the backlog is not handed to the encoder in that same cycle. Then that pattern is discarded, and `overflow_o` is high for the one cycle after the frame cycle. Words already queued are unaffected.
- R8: While `rst` is high, and in the cycle after it, `out_valid` and `overflow_o` are 0.
- R9: When the block is idle, the first word of a slice is valid in the second cycle after its frame cycle. It is visible after the second rising edge that follows the frame edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock (eight cycles per sample) |
| rst | input | 1 | Synchronous active-high reset |
| lane_i | input | 8 | One serial bit per lane per cycle |
| frame_i | input | 1 | High in the cycle carrying the eighth bit of each byte |
| ts_i | input | 32 | Global sample timestamp counter |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_ts | output | 32 | Timestamp of the slice |
| out_addr | output | 9 | Global strip coordinate |
| out_last | output | 1 | Final word of the slice |
| overflow_o | output | 1 | One-cycle pulse: a non-empty slice was dropped |

## Verification
A wrong bit in a lane shift register or in the backlog shows up as a wrong or missing strip address. This appears at the ports two cycles after the frame edge. A wrong mask bit in the encoder appears as a skipped, repeated or out-of-order address, or a misplaced last flag, on the next accepted word. Backlog bookkeeping errors show up as an overflow pulse in the wrong cycle, or as a whole slice arriving or vanishing. The reference model predicts every output every cycle, so any such fault is reported within one cycle of reaching the ports.

// File: rtl/strip_hit_pkg.sv
package strip_hit_pkg;

    localparam int LANES     = 8;
    localparam int LANE_BITS = 8;
    localparam int PAT_W     = LANES * LANE_BITS;
    localparam int LOC_W     = $clog2(PAT_W);
    localparam int CHIP_W    = 2;
    localparam int GADDR_W   = 1 + CHIP_W + LOC_W;
    localparam int TS_W      = 32;

    typedef logic [PAT_W-1:0]   pattern_t;
    typedef logic [TS_W-1:0]    stamp_t;
    typedef logic [LOC_W-1:0]   local_t;
    typedef logic [GADDR_W-1:0] gaddr_t;

    typedef struct packed {
        logic     valid;
        stamp_t   ts;
        pattern_t hits;
    } slice_t;

    typedef struct packed {
        stamp_t ts;
        gaddr_t addr;
        logic   last;
    } hit_word_t;

    // index of the lowest set bit (0 when none)
    function automatic local_t lowest_hit(input pattern_t p);
        local_t idx;
        idx = '0;
        for (int i = PAT_W - 1; i >= 0; i--) begin
            if (p[i]) idx = local_t'(i);
        end
        return idx;
    endfunction

    function automatic pattern_t clear_lowest(input pattern_t p);
        return p & (p - pattern_t'(1));
    endfunction

    function automatic gaddr_t make_gaddr(input logic side, input logic [CHIP_W-1:0] chip,
                                          input local_t loc);
        return {side, chip, loc};
    endfunction

endpackage

// File: rtl/lane_deser.sv
module lane_deser
    import strip_hit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lane_i,
    input  logic             frame_i,
    input  stamp_t           ts_i,
    output slice_t           cap_o
);
    pattern_t assembled;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_BITS-2:0] shreg;

        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[LANE_BITS-3:0], lane_i[k]};
        end

        // earliest bit lands in the byte MSB
        assign assembled[k*LANE_BITS +: LANE_BITS] = {shreg, lane_i[k]};
    end

    always_comb begin
        cap_o.valid = frame_i;
        cap_o.ts    = ts_i;
        cap_o.hits  = assembled;
    end
endmodule

// File: rtl/slice_backlog.sv
module slice_backlog
    import strip_hit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  slice_t cap_i,
    input  logic   take_i,
    output slice_t bk_o,
    output logic   ovf_o
);
    slice_t bk_q;
    logic   ovf_q;
    logic   incoming;
    logic   accept;

    assign incoming = cap_i.valid && (cap_i.hits != '0);
    assign accept   = incoming && (!bk_q.valid || take_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= incoming && bk_q.valid && !take_i;
            if (accept) begin
                bk_q.valid <= 1'b1;
                bk_q.ts    <= cap_i.ts;
                bk_q.hits  <= cap_i.hits;
            end else if (take_i) begin
                bk_q.valid <= 1'b0;
            end
        end
    end

    assign bk_o  = bk_q;
    assign ovf_o = ovf_q;
endmodule

// File: rtl/hit_encoder.sv
module hit_encoder
    import strip_hit_pkg::*;
#(
    parameter logic              SIDE_ID = 1'b0,
    parameter logic [CHIP_W-1:0] CHIP_ID = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  slice_t    bk_i,
    output logic      take_o,
    output logic      valid_o,
    input  logic      ready_i,
    output hit_word_t word_o
);
    pattern_t mask_q;
    stamp_t   ts_q;
    pattern_t rest;
    logic     fire;

    assign valid_o = (mask_q != '0);
    assign fire    = valid_o && ready_i;
    assign rest    = fire ? clear_lowest(mask_q) : mask_q;
    assign take_o  = (rest == '0) && bk_i.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ts_q   <= '0;
        end else if (take_o) begin
            mask_q <= bk_i.hits;
            ts_q   <= bk_i.ts;
        end else begin
            mask_q <= rest;
        end
    end

    always_comb begin
        word_o.ts   = ts_q;
        word_o.addr = make_gaddr(SIDE_ID, CHIP_ID, lowest_hit(mask_q));
        word_o.last = (clear_lowest(mask_q) == '0);
    end
endmodule

// File: rtl/strip_hit_decoder.sv
module strip_hit_decoder
    import strip_hit_pkg::*;
#(
    parameter logic              SIDE_ID = 1'b0,
    parameter logic [CHIP_W-1:0] CHIP_ID = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   lane_i,
    input  logic               frame_i,
    input  logic [TS_W-1:0]    ts_i,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [TS_W-1:0]    out_ts,
    output logic [GADDR_W-1:0] out_addr,
    output logic               out_last,
    output logic               overflow_o
);
    slice_t    cap;
    slice_t    bk;
    logic      take;
    logic      bk_valid;
    hit_word_t word;

    lane_deser u_deser (
        .clk     (clk),
        .rst     (rst),
        .lane_i  (lane_i),
        .frame_i (frame_i),
        .ts_i    (ts_i),
        .cap_o   (cap)
    );

    slice_backlog u_backlog (
        .clk    (clk),
        .rst    (rst),
        .cap_i  (cap),
        .take_i (take),
        .bk_o   (bk),
        .ovf_o  (overflow_o)
    );

    hit_encoder #(
        .SIDE_ID (SIDE_ID),
        .CHIP_ID (CHIP_ID)
    ) u_enc (
        .clk     (clk),
        .rst     (rst),
        .bk_i    (bk),
        .take_o  (take),
        .valid_o (out_valid),
        .ready_i (out_ready),
        .word_o  (word)
    );

    assign bk_valid = bk.valid;
    assign out_ts   = word.ts;
    assign out_addr = word.addr;
    assign out_last = word.last;
endmodule

// File: rtl/strip_hit_decoder_chk.sv
module strip_hit_decoder_chk
    import strip_hit_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               frame_i,
    input logic               out_valid,
    input logic               out_ready,
    input logic [TS_W-1:0]    out_ts,
    input logic [GADDR_W-1:0] out_addr,
    input logic               out_last,
    input logic               overflow_o,
    input logic               bk_valid
);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_ts)
                                    && $stable(out_last));

    p_ascend_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid && (out_addr > $past(out_addr)));

    p_ovf_frame_r7: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> $past(frame_i) && $past(bk_valid));

    p_reset_r8: assert property (@(posedge clk)
        rst |=> !out_valid && !overflow_o);

    p_source_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(bk_valid));
endmodule

bind strip_hit_decoder strip_hit_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_i    (frame_i),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_ts     (out_ts),
    .out_addr   (out_addr),
    .out_last   (out_last),
    .overflow_o (overflow_o),
    .bk_valid   (bk_valid)
);

// File: tb/strip_hit_decoder_bench.sv
`timescale 1ns/1ps
module strip_hit_decoder_bench;
    localparam logic       SIDE = 1'b1;
    localparam logic [1:0] CHIP = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  lane = '0;
    logic        frame = 1'b0;
    logic [31:0] ts = 32'hFFFF_FFFC;
    logic        rdy = 1'b1;
    logic [63:0] cur_pat = '0;

    logic        out_valid, out_last, overflow_o;
    logic [31:0] out_ts;
    logic [8:0]  out_addr;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    running = 0;
    bit    done = 0;
    string tag = "R8";

    // model state: each word is {ts, addr, last}
    logic [41:0] act_q[$];
    logic [41:0] bk_q[$];
    bit          bk_has = 0;
    bit          exp_ovf = 0;

    always #10 clk = ~clk;

    strip_hit_decoder #(.SIDE_ID(SIDE), .CHIP_ID(CHIP)) u_strip_hit_decoder (
        .clk(clk), .rst(rst), .lane_i(lane), .frame_i(frame), .ts_i(ts),
        .out_valid(out_valid), .out_ready(rdy), .out_ts(out_ts), .out_addr(out_addr),
        .out_last(out_last), .overflow_o(overflow_o)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic fill_backlog(input logic [63:0] p, input logic [31:0] t);
        bk_q.delete();
        for (int i = 0; i < 64; i++)
            if (p[i]) bk_q.push_back({t, SIDE, CHIP, 6'(i), 1'b0});
        bk_q[bk_q.size()-1][0] = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            act_q.delete(); bk_q.delete(); bk_has = 0; exp_ovf = 0;
        end else begin
            if (act_q.size() > 0 && rdy) void'(act_q.pop_front());
            if (act_q.size() == 0 && bk_has) begin act_q = bk_q; bk_has = 0; end
            exp_ovf = 0;
            if (frame && cur_pat != '0) begin
                if (bk_has) exp_ovf = 1;
                else begin fill_backlog(cur_pat, ts); bk_has = 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (running && !rst) begin
            check(out_valid == (act_q.size() > 0), "valid (R4 R9)", 64'(out_valid),
                  64'(act_q.size() > 0));
            if (out_valid && act_q.size() > 0) begin
                check(out_addr == act_q[0][9:1], "addr (R1 R5)", 64'(out_addr),
                      64'(act_q[0][9:1]));
                check(out_ts == act_q[0][41:10], "ts (R2)", 64'(out_ts),
                      64'(act_q[0][41:10]));
                check(out_last == act_q[0][0], "last (R4)", 64'(out_last),
                      64'(act_q[0][0]));
            end
            check(overflow_o == exp_ovf, "overflow (R3 R7)", 64'(overflow_o), 64'(exp_ovf));
        end
    end

    task automatic send(input logic [63:0] p);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (j == 0) ts = ts + 1;
            for (int k = 0; k < 8; k++) lane[k] = p[8*k + 7 - j];
            frame = (j == 7);
            cur_pat = p;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lane = '0; frame = 1'b0; cur_pat = '0;
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    initial begin
        // R8: reset state
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0 || i == 0, "reset valid R8", 64'(out_valid), 64'd0);
            check(overflow_o == 1'b0 || i == 0, "reset ovf R8", 64'(overflow_o), 64'd0);
        end
        @(negedge clk); rst = 1'b0; running = 1;
        check(out_valid == 1'b0, "post-reset valid R8", 64'(out_valid), 64'd0);

        tag = "R1 R5 R9";
        send(64'h0000_0000_0000_0001); idle(6);
        send(64'h8000_0000_0000_0000); idle(6);
        send(64'h0000_0000_0000_0080); idle(6);
        send(64'h0100_0000_0000_8000); idle(8);

        tag = "R4";
        send(64'h8421_0000_F000_0103); idle(20);

        tag = "R3";
        send(64'h0); idle(4);
        send(64'h0000_00FF_0000_0000); send(64'h0); send(64'h0); idle(12);

        tag = "R2";
        for (int i = 0; i < 6; i++) send(64'h1 << (i * 9));
        idle(10);

        tag = "R6";
        for (int i = 0; i < 40; i++) begin
            logic [63:0] p;
            p = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                rdy = $urandom_range(0, 3) != 0;
                if (j == 0) ts = ts + 1;
                for (int k = 0; k < 8; k++) lane[k] = p[8*k + 7 - j];
                frame = (j == 7);
                cur_pat = p;
            end
        end
        @(negedge clk); rdy = 1'b1;
        idle(200);

        tag = "R7";
        send('1); send('1); send('1); send(64'h5); idle(150);
        rdy = 1'b0;
        send(64'h3); send(64'h30); send(64'h300); idle(4);
        rdy = 1'b1; idle(20);

        done = 1;
        summary();
    end
endmodule